// File: doc/BRIEF.md
# Blanking-Synchronized Video Memory DMA

This block copies data into an 8 KB video memory window in blocks of 16 bytes. Five byte-wide registers set it up. Two registers give a 16-byte-aligned source address anywhere in the 64 KB space. Two more give a 16-byte-aligned destination offset inside the window at 0x8000-0x9FFF. A control register gives the block count and selects the mode.

The two modes share the same registers. In general mode, the write to the control register starts a copy of every block, back to back. Blanking mode is armed by that write and moves exactly one block on each qualifying rising edge of the horizontal-blank input. A qualifying edge is one that arrives while the display-enable input is high. A blanking transfer can be stopped at its next edge and resumed later. A resumed transfer continues from the addresses that were already reached.

The CPU halt output is high during every cycle in which bytes are being moved. Each byte takes two cycles: one read and one write. The copy speed therefore does not depend on any CPU speed setting.

Top module: `vdma_engine`

## Requirements
- R1: Byte k (0-15) of each block is read from address {reg0[7:0], reg1[7:4], k}, where k is the 4-bit offset within the block. The low nibble of reg1 has no effect.
- R2: Byte k of each block is written to address 0x8000 + {reg2[4:0], reg3[7:4], k}. Bits 7-5 of reg2 and bits 3-0 of reg3 have no effect. The 9-bit block offset wraps inside the window.
- R3: Writing reg4 with value n in bits 6-0 sets up n+1 blocks of 16 bytes, so 16 to 2048 bytes. After each block, both addresses advance by 16. Exactly 16*(n+1) bytes are written.
- R4: While idle, writing reg4 with bit 7 = 0 starts general mode on the next cycle. All blocks then run back to back, and cpu_halt_o stays high for exactly 32*(n+1) cycles. Register writes made during the copy have no effect.
- R5: While idle, writing reg4 with bit 7 = 1 arms blanking mode and moves nothing until a qualifying rising edge of hblank_i. Each such edge moves exactly one block, starting in the cycle after the edge.
- R6: A rising edge of hblank_i has no effect if disp_en_i is low. An edge that arrives while a block is being copied is dropped rather than queued.
- R7: While blanking mode is armed, writing reg4 with bit 7 = 0 causes the next qualifying edge to end the transfer without copying. A later write with bit 7 = 1 resumes from the next block's addresses.
- R8: Reading reg4 returns {idle, remaining blocks - 1}. Bit 7 is 0 while a transfer is armed or copying, and the register reads 0xFF after a transfer completes and after reset. Reads of reg0-reg3 return 0xFF.
- R9: cpu_halt_o is high only during byte moves. Each byte takes two cycles: a read cycle (mem_re_o) and then a write cycle (mem_we_o). The write carries mem_rdata_i, which the memory returns one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index 0-4 |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| mem_addr_o | output | 16 | Memory address |
| mem_re_o | output | 1 | Memory read request |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after mem_re_o |
| hblank_i | input | 1 | Horizontal-blank level |
| disp_en_i | input | 1 | Display enable |
| cpu_halt_o | output | 1 | CPU stall while bytes move |

## Verification
The assertions assume that the memory returns read data exactly one cycle after a read request. They also assume that software writes the registers only while the CPU is not halted, and that a control write never lands in the same cycle as a horizontal-blank edge. The bench uses a memory model with a fixed one-cycle read latency. It issues register writes only at points where it knows the engine's state. It raises hblank_i only while no register write is pending. The one exception is a deliberate group of writes made during a halt, which checks that such writes have no effect.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 16;
  localparam int unsigned WIN_AW  = 13;
  localparam int unsigned REG_AW  = 3;
  localparam int unsigned BLK_LG  = 4;
  localparam int unsigned LEN_W   = 7;
  localparam int unsigned SRC_BW  = AW - BLK_LG;
  localparam int unsigned DST_BW  = WIN_AW - BLK_LG;
  localparam logic [AW-WIN_AW-1:0] WIN_TAG = 3'b100;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_COPY} st_e;
  typedef enum logic {MODE_GEN, MODE_BLANK} mode_e;
endpackage

// File: rtl/vdma_hb_edge.sv
module vdma_hb_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hblank_i,
  input  logic disp_en_i,
  output logic edge_o
);
  logic hb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hb_q <= 1'b0;
    else         hb_q <= hblank_i;
  end

  assign edge_o = hblank_i & ~hb_q & disp_en_i;
endmodule

// File: rtl/vdma_copy.sv
module vdma_copy
  import vdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [SRC_BW-1:0] src_blk_i,
  input  logic [DST_BW-1:0] dst_blk_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              blk_done_o
);
  logic              wr_phase_q;
  logic [BLK_LG-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_phase_q <= 1'b0;
      idx_q      <= '0;
    end else if (!go_i) begin
      wr_phase_q <= 1'b0;
      idx_q      <= '0;
    end else begin
      wr_phase_q <= ~wr_phase_q;
      if (wr_phase_q) idx_q <= idx_q + 1'b1;
    end
  end

  assign mem_re_o    = go_i & ~wr_phase_q;
  assign mem_we_o    = go_i & wr_phase_q;
  assign mem_addr_o  = wr_phase_q ? {WIN_TAG, dst_blk_i, idx_q} : {src_blk_i, idx_q};
  assign mem_wdata_o = mem_rdata_i;
  assign blk_done_o  = go_i & wr_phase_q & (&idx_q);

  assert_rw_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  assert_wr_after_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(mem_re_o));
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              hb_edge_i,
  input  logic              blk_done_i,
  output logic              go_o,
  output logic [SRC_BW-1:0] src_blk_o,
  output logic [DST_BW-1:0] dst_blk_o
);
  localparam logic [REG_AW-1:0] IDX_SRC_HI = 3'd0;
  localparam logic [REG_AW-1:0] IDX_SRC_LO = 3'd1;
  localparam logic [REG_AW-1:0] IDX_DST_HI = 3'd2;
  localparam logic [REG_AW-1:0] IDX_DST_LO = 3'd3;
  localparam logic [REG_AW-1:0] IDX_CTRL   = 3'd4;
  localparam int unsigned SRC_HI_W = SRC_BW - BLK_LG;
  localparam int unsigned DST_HI_W = DST_BW - BLK_LG;

  st_e               st_q;
  mode_e             mode_q;
  logic [LEN_W-1:0]  rem_q;
  logic              stop_q;
  logic [SRC_BW-1:0] src_q;
  logic [DST_BW-1:0] dst_q;
  logic              cfg_wr, ctrl_wr;

  assign cfg_wr  = reg_we_i && (st_q != ST_COPY);
  assign ctrl_wr = cfg_wr && (reg_addr_i == IDX_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_GEN;
      rem_q  <= '1;
      stop_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      if (cfg_wr) begin
        case (reg_addr_i)
          IDX_SRC_HI: src_q[SRC_BW-1:BLK_LG] <= reg_wdata_i[SRC_HI_W-1:0];
          IDX_SRC_LO: src_q[BLK_LG-1:0]      <= reg_wdata_i[DW-1:DW-BLK_LG];
          IDX_DST_HI: dst_q[DST_BW-1:BLK_LG] <= reg_wdata_i[DST_HI_W-1:0];
          IDX_DST_LO: dst_q[BLK_LG-1:0]      <= reg_wdata_i[DW-1:DW-BLK_LG];
          default: ;
        endcase
      end
      case (st_q)
        ST_IDLE: begin
          if (ctrl_wr) begin
            rem_q  <= reg_wdata_i[LEN_W-1:0];
            stop_q <= 1'b0;
            if (reg_wdata_i[DW-1]) begin
              mode_q <= MODE_BLANK;
              st_q   <= ST_WAIT;
            end else begin
              mode_q <= MODE_GEN;
              st_q   <= ST_COPY;
            end
          end
        end
        ST_WAIT: begin
          if (ctrl_wr) begin
            if (reg_wdata_i[DW-1]) begin
              rem_q  <= reg_wdata_i[LEN_W-1:0];
              stop_q <= 1'b0;
            end else begin
              stop_q <= 1'b1;
            end
          end
          if (hb_edge_i) begin
            stop_q <= 1'b0;
            st_q   <= stop_q ? ST_IDLE : ST_COPY;
          end
        end
        ST_COPY: begin
          if (blk_done_i) begin
            src_q <= src_q + 1'b1;
            dst_q <= dst_q + 1'b1;
            rem_q <= rem_q - 1'b1;
            if (rem_q == '0)            st_q <= ST_IDLE;
            else if (mode_q == MODE_GEN) st_q <= ST_COPY;
            else                         st_q <= ST_WAIT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign go_o        = (st_q == ST_COPY);
  assign src_blk_o   = src_q;
  assign dst_blk_o   = dst_q;
  assign reg_rdata_o = (reg_addr_i == IDX_CTRL) ? {st_q == ST_IDLE, rem_q} : '1;

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_i |=> (src_q == SRC_BW'($past(src_q) + 1'b1)) &&
                   (dst_q == DST_BW'($past(dst_q) + 1'b1)));
  assert_rem_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_done_i |=> rem_q == LEN_W'($past(rem_q) - 1'b1));
  assert_gen_no_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COPY && mode_q == MODE_GEN && !blk_done_i) |=> st_q == ST_COPY);
  assert_one_blk_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COPY && mode_q == MODE_BLANK && blk_done_i) |=> st_q != ST_COPY);
  assert_busy_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (reg_addr_i != IDX_CTRL) || !reg_rdata_o[DW-1]);
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              hblank_i,
  input  logic              disp_en_i,
  output logic              cpu_halt_o
);
  logic              hb_edge, blk_done, go;
  logic [SRC_BW-1:0] src_blk;
  logic [DST_BW-1:0] dst_blk;

  vdma_hb_edge u_hb_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hblank_i  (hblank_i),
    .disp_en_i (disp_en_i),
    .edge_o    (hb_edge)
  );

  vdma_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .hb_edge_i   (hb_edge),
    .blk_done_i  (blk_done),
    .go_o        (go),
    .src_blk_o   (src_blk),
    .dst_blk_o   (dst_blk)
  );

  vdma_copy u_copy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .src_blk_i   (src_blk),
    .dst_blk_i   (dst_blk),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .blk_done_o  (blk_done)
  );

  assign cpu_halt_o = go;

  assert_halt_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_halt_o |-> !mem_re_o && !mem_we_o);
  assert_start_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_halt_o) |-> $past(reg_we_i) || ($past(hblank_i) && $past(disp_en_i)));
  assert_win_dest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[AW-1:WIN_AW] == WIN_TAG);
endmodule

// File: tb/vdma_engine_bench.sv
module vdma_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [2:0] reg_addr_i = 3'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic [15:0] mem_addr_o;
  logic       mem_re_o, mem_we_o;
  logic [7:0] mem_wdata_o;
  logic [7:0] rdata_q = 8'd0;
  logic       hblank_i = 1'b0;
  logic       disp_en_i = 1'b0;
  logic       cpu_halt_o;

  int n_chk = 0;
  int n_fail = 0;
  int wr_total = 0;
  int stray = 0;
  int halt_cyc = 0;
  bit clr = 1'b0;
  logic [7:0] vram [0:8191];

  always #4 clk = ~clk;

  vdma_engine u_vdma_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mem_addr_o(mem_addr_o),
    .mem_re_o(mem_re_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(rdata_q), .hblank_i(hblank_i), .disp_en_i(disp_en_i),
    .cpu_halt_o(cpu_halt_o)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (clr) for (int i = 0; i < 8192; i++) vram[i] <= 8'd0;
    if (cpu_halt_o) halt_cyc <= halt_cyc + 1;
    if (mem_re_o) rdata_q <= pat(mem_addr_o);
    if (mem_we_o) begin
      wr_total <= wr_total + 1;
      if (mem_addr_o[15:13] == 3'b100) vram[mem_addr_o[12:0]] <= mem_wdata_o;
      else stray <= stray + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic clear_vram();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (cpu_halt_o && guard < 10000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic hb_pulse();
    @(negedge clk); hblank_i = 1'b1;
    @(negedge clk);
    @(negedge clk); hblank_i = 1'b0;
  endtask

  task automatic check_region(input logic [15:0] src, input logic [12:0] dst,
                              input int nbytes, input string req);
    int mis = 0;
    int first_act = 0;
    int first_exp = 0;
    for (int k = 0; k < nbytes; k++) begin
      logic [12:0] di;
      logic [15:0] si;
      di = dst + 13'(k);
      si = src + 16'(k);
      if (vram[di] !== pat(si)) begin
        if (mis == 0) begin first_act = int'(vram[di]); first_exp = int'(pat(si)); end
        mis++;
      end
    end
    chk(mis == 0, req, first_act, first_exp);
  endtask

  task automatic set_addr(input logic [15:0] src, input logic [12:0] dst);
    wr(3'd0, src[15:8]);
    wr(3'd1, {src[7:4], 4'hF});
    wr(3'd2, {3'b111, dst[12:8]});
    wr(3'd3, {dst[7:4], 4'hA});
  endtask

  task automatic gdma_case(input logic [15:0] src, input logic [12:0] dst, input int n);
    int h0, w0, s0;
    logic [7:0] st;
    clear_vram();
    set_addr(src, dst);
    h0 = halt_cyc; w0 = wr_total; s0 = stray;
    wr(3'd4, {1'b0, 7'(n)});
    wait_idle();
    @(negedge clk);
    check_region(src, dst, 16 * (n + 1), "R1/R2 data at composed addresses");
    chk(wr_total - w0 == 16 * (n + 1), "R3 byte count", wr_total - w0, 16 * (n + 1));
    chk(halt_cyc - h0 == 32 * (n + 1), "R4/R9 halt cycles", halt_cyc - h0, 32 * (n + 1));
    chk(stray == s0, "R2 writes in window", stray, s0);
    rd(3'd4, st);
    chk(st == 8'hFF, "R8 status after completion", st, 8'hFF);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] st;
    int h0, w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd4, st);
    chk(st == 8'hFF, "R8 reset status", st, 8'hFF);
    rd(3'd0, st);
    chk(st == 8'hFF, "R8 non-control read", st, 8'hFF);
    chk(!cpu_halt_o && !mem_re_o && !mem_we_o, "R9 idle after reset", cpu_halt_o, 0);

    // general mode sweep
    for (int n = 0; n < 8; n++)
      gdma_case(16'h0100 * 16'(n) + 16'h0040, 13'h0230 * 13'(n) + 13'h0010, n);
    gdma_case(16'h4560, 13'h1FF0, 1);          // R2 window wrap
    gdma_case(16'hC000, 13'h0000, 127);        // R3 max length

    // R4 writes during a general copy have no effect
    clear_vram();
    set_addr(16'h2200, 13'h0400);
    w0 = wr_total;
    wr(3'd4, 8'h01);
    wr(3'd4, 8'h85);
    wr(3'd0, 8'h00);
    wait_idle();
    @(negedge clk);
    check_region(16'h2200, 13'h0400, 32, "R4 copy unaffected by writes");
    chk(wr_total - w0 == 32, "R4 length unaffected by writes", wr_total - w0, 32);
    rd(3'd4, st);
    chk(st == 8'hFF, "R4 idle after copy", st, 8'hFF);

    // blanking mode
    clear_vram();
    set_addr(16'h3300, 13'h0800);
    h0 = halt_cyc; w0 = wr_total;
    disp_en_i = 1'b1;
    wr(3'd4, 8'h82);
    repeat (20) @(negedge clk);
    chk(halt_cyc == h0, "R5 armed moves nothing", halt_cyc - h0, 0);
    rd(3'd4, st);
    chk(st == 8'h02, "R8 armed status", st, 8'h02);
    disp_en_i = 1'b0;
    hb_pulse();
    repeat (5) @(negedge clk);
    chk(halt_cyc == h0, "R6 edge ignored with display off", halt_cyc - h0, 0);
    disp_en_i = 1'b1;
    hb_pulse();
    repeat (4) @(negedge clk);
    hblank_i = 1'b1;                            // R6 edge during copy
    repeat (2) @(negedge clk);
    hblank_i = 1'b0;
    wait_idle();
    repeat (40) @(negedge clk);
    chk(halt_cyc - h0 == 32, "R5/R6 one block per edge", halt_cyc - h0, 32);
    rd(3'd4, st);
    chk(st == 8'h01, "R8 remaining after one block", st, 8'h01);

    // R7 stop then resume
    wr(3'd4, 8'h00);
    rd(3'd4, st);
    chk(st[7] == 1'b0, "R7 still busy before edge", st, 8'h01);
    hb_pulse();
    repeat (5) @(negedge clk);
    chk(halt_cyc - h0 == 32, "R7 stop edge copies nothing", halt_cyc - h0, 32);
    rd(3'd4, st);
    chk(st == 8'h81, "R7 stopped status", st, 8'h81);
    wr(3'd4, 8'h80);
    rd(3'd4, st);
    chk(st == 8'h00, "R7 re-armed status", st, 8'h00);
    hb_pulse();
    wait_idle();
    @(negedge clk);
    check_region(16'h3300, 13'h0800, 32, "R7 resumed at next block");
    chk(wr_total - w0 == 32, "R7 total bytes", wr_total - w0, 32);
    rd(3'd4, st);
    chk(st == 8'hFF, "R8 blanking complete status", st, 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule